// File: doc/BRIEF.md
# Sampling ADC Capture Controller

This block sits on the digital side of an external edge-triggered sampling converter with a 14-bit parallel result bus. The converter begins a conversion on a rising start edge and raises its busy line (EOC) while it works. The controller produces the start pulses at a programmable sample period and keeps the pulse width inside the converter's legal timing window. After EOC falls it captures the result and passes it on as a one-cycle valid strobe with the data word.

The converter also has a coding-select line and an active-low output-enable line. The controller owns both. Requested changes are held and driven onto the pins only while no conversion is running, so neither line moves between the start pulse's falling edge and the fall of EOC. While enabled, the controller keeps the converter running without a break, which also covers the warm-up period. A conversion whose EOC never falls sets a sticky error flag.

All timing is set in nanoseconds through parameters and turned into clock cycles. At the default 4 ns clock the start pulse is 20 cycles (80 ns). The shortest sample period is pulse plus maximum conversion time, 60 cycles, and the timeout is 100 cycles.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is asserted and right after it, startConv is 0, sampleValid is 0, errFlag is 0, codingSel is 0 and outEnN is 1.
- R2: Every start pulse is high for exactly PULSE_NS/CLK_NS cycles when PULSE_NS lies in 40..80 ns or 130..160 ns. Any other setting falls back to 80 ns (20 cycles at the default clock).
- R3: While enable stays high, consecutive start rising edges are max(periodCycles, MIN_PERIOD) cycles apart. MIN_PERIOD is the pulse cycles plus CONV_MAX_NS/CLK_NS (60 by default), so shorter or zero settings are clamped to it.
- R4: A start rising edge is never issued in the cycle after eoc was sampled high. A converter whose EOC stays high gets no new start until EOC returns low.
- R5: The word on adcData is captured at the first clock edge that sees EOC low after having seen it high. sampleValid is then high for exactly one cycle with that word on sampleData.
- R6: codingSel and outEnN change only while no conversion runs: never from the fall of startConv until EOC has been seen low (or the timeout has ended the conversion).
- R7: codingSel follows reqCoding, where 1 selects complementary offset binary and 0 selects plain offset binary. The captured word is in the requested coding once the change has been applied.
- R8: outEnN is the inverse of reqRead, so reqRead=1 drives the bus-enable low. While outEnN is 1, no sampleValid is produced.
- R9: If EOC has not fallen within TIMEOUT_NS/CLK_NS cycles of the start edge, errFlag is set. It stays set until reset, and conversion continues with the next period.
- R10: With enable low, no new start edge is issued. With enable high, conversions repeat without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run continuous conversions |
| periodCycles | input | 16 | Requested sample period in clock cycles |
| reqCoding | input | 1 | Requested coding: 1 complementary offset binary, 0 offset binary |
| reqRead | input | 1 | Request the converter bus enabled |
| eoc | input | 1 | Converter busy line, high during conversion |
| adcData | input | 14 | Converter result bus |
| startConv | output | 1 | Start-convert pulse to the converter |
| codingSel | output | 1 | Coding-select line to the converter |
| outEnN | output | 1 | Active-low bus enable to the converter |
| sampleValid | output | 1 | One-cycle strobe for a captured sample |
| sampleData | output | 14 | Captured sample word |
| errFlag | output | 1 | Sticky conversion-timeout flag |

## Verification
The checks assume the converter raises EOC only after a start edge and drops it well within one minimum period. They also assume it never raises EOC on its own while idle, except in the deliberate stuck-high case. The bench's converter model uses a fixed 10-cycle rise and 45-cycle fall after each start it sees. It holds EOC high on request to imitate a stuck converter, and it can skip EOC for one conversion to force the timeout. Configuration requests are changed both in the idle gap and in the middle of a conversion. The requested period is never raised above the timeout window.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_CONV  = 2'd2,
    ST_GAP   = 2'd3
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;     // restart period counter at a start edge
    logic latchWord;  // capture the bus word
    logic setErr;     // set sticky timeout flag
    logic applyCfg;   // drive staged coding/enable onto pins
  } capStrobe_t;

  // legal start-pulse windows in ns
  function automatic bit pulseLegal(int ns);
    return ((ns >= 40) && (ns <= 80)) || ((ns >= 130) && (ns <= 160));
  endfunction

endpackage

// File: rtl/adc_cap_datapath.sv
module adc_cap_datapath
  import adc_cap_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CNT_W       = 16,
  parameter int MIN_PERIOD  = 60,
  parameter int TIMEOUT_CYC = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [CNT_W-1:0]  periodCycles,
  input  logic              reqCoding,
  input  logic              reqRead,
  input  logic              eoc,
  input  logic [DATA_W-1:0] adcData,
  output logic [CNT_W-1:0]  cntVal,
  output logic              periodDone,
  output logic              timedOut,
  output logic              eocFall,
  output logic              codingSel,
  output logic              outEnN,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              errFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_P     = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] TOUT      = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] effPeriod;
  logic             eocQ;

  // period clamp
  always_comb begin
    if (periodCycles < MIN_P) effPeriod = MIN_P;
    else                      effPeriod = periodCycles;
  end

  // cycles since the last start edge, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.cntClr)   cnt <= CNT_W'(1);
    else if (cnt != CNT_MAX)  cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) eocQ <= 1'b0;
    else       eocQ <= eoc;
  end

  assign cntVal     = cnt;
  assign periodDone = (cnt >= effPeriod);
  assign timedOut   = (cnt >= TOUT);
  assign eocFall    = eocQ & ~eoc;

  // capture register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleValid <= 1'b0;
      sampleData  <= '0;
    end else if (strobe.latchWord && !outEnN) begin
      sampleValid <= 1'b1;
      sampleData  <= adcData;
    end else begin
      sampleValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              errFlag <= 1'b0;
    else if (strobe.setErr) errFlag <= 1'b1;
  end

  // configuration pins, moved only when control allows
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codingSel <= 1'b0;
      outEnN    <= 1'b1;
    end else if (strobe.applyCfg) begin
      codingSel <= reqCoding;
      outEnN    <= ~reqRead;
    end
  end

endmodule

// File: rtl/adc_cap_control.sv
module adc_cap_control
  import adc_cap_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PULSE_CYC = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             eoc,
  input  logic             eocFall,
  input  logic             periodDone,
  input  logic             timedOut,
  input  logic [CNT_W-1:0] cntVal,
  output capStrobe_t       strobe,
  output logic             startConv
);

  localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC);

  capState_t state, stateNext;
  logic      startNext;

  always_comb begin
    stateNext        = state;
    startNext        = 1'b0;
    strobe           = '0;
    strobe.applyCfg  = (state == ST_IDLE) || (state == ST_GAP);
    unique case (state)
      ST_IDLE: begin
        if (enable && !eoc) begin
          strobe.cntClr = 1'b1;
          startNext     = 1'b1;
          stateNext     = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (cntVal >= PULSE_END) stateNext = ST_CONV;
        else                     startNext = 1'b1;
      end
      ST_CONV: begin
        if (eocFall) begin
          strobe.latchWord = 1'b1;
          stateNext        = ST_GAP;
        end else if (timedOut) begin
          strobe.setErr = 1'b1;
          stateNext     = ST_GAP;
        end
      end
      ST_GAP: begin
        if (!enable) begin
          stateNext = ST_IDLE;
        end else if (periodDone && !eoc) begin
          strobe.cntClr = 1'b1;
          startNext     = 1'b1;
          stateNext     = ST_PULSE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startConv <= 1'b0;
    end else begin
      state     <= stateNext;
      startConv <= startNext;
    end
  end

endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import adc_cap_pkg::*;
#(
  parameter int CLK_NS      = 4,
  parameter int PULSE_NS    = 80,
  parameter int CONV_MAX_NS = 160,
  parameter int TIMEOUT_NS  = 400,
  parameter int DATA_W      = 14,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CNT_W-1:0]  periodCycles,
  input  logic              reqCoding,
  input  logic              reqRead,
  input  logic              eoc,
  input  logic [DATA_W-1:0] adcData,
  output logic              startConv,
  output logic              codingSel,
  output logic              outEnN,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              errFlag
);

  localparam int PULSE_USE_NS = pulseLegal(PULSE_NS) ? PULSE_NS : 80;
  localparam int PULSE_USE    = PULSE_USE_NS / CLK_NS;
  localparam int MIN_PERIOD   = PULSE_USE + (CONV_MAX_NS / CLK_NS);
  localparam int TIMEOUT_CYC  = TIMEOUT_NS / CLK_NS;

  capStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic             periodDone;
  logic             timedOut;
  logic             eocFall;

  adc_cap_control #(
    .CNT_W     (CNT_W),
    .PULSE_CYC (PULSE_USE)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .eoc        (eoc),
    .eocFall    (eocFall),
    .periodDone (periodDone),
    .timedOut   (timedOut),
    .cntVal     (cntVal),
    .strobe     (strobe),
    .startConv  (startConv)
  );

  adc_cap_datapath #(
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .MIN_PERIOD  (MIN_PERIOD),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .periodCycles (periodCycles),
    .reqCoding    (reqCoding),
    .reqRead      (reqRead),
    .eoc          (eoc),
    .adcData      (adcData),
    .cntVal       (cntVal),
    .periodDone   (periodDone),
    .timedOut     (timedOut),
    .eocFall      (eocFall),
    .codingSel    (codingSel),
    .outEnN       (outEnN),
    .sampleValid  (sampleValid),
    .sampleData   (sampleData),
    .errFlag      (errFlag)
  );

endmodule

// File: rtl/adc_cap_checker.sv
module adc_cap_checker #(
  parameter int PULSE_CYC   = 20,
  parameter int MIN_PERIOD  = 60,
  parameter int TIMEOUT_CYC = 100
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic eoc,
  input logic startConv,
  input logic codingSel,
  input logic outEnN,
  input logic sampleValid,
  input logic errFlag
);

  logic       stPrev;
  logic       eocPrev;
  logic [7:0] hiCnt;
  logic [15:0] sinceRise;
  logic       seenRise;
  logic       busyQ;
  logic [15:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stPrev    <= 1'b0;
      eocPrev   <= 1'b0;
      hiCnt     <= '0;
      sinceRise <= '0;
      seenRise  <= 1'b0;
      busyQ     <= 1'b0;
      busyCnt   <= '0;
    end else begin
      stPrev  <= startConv;
      eocPrev <= eoc;
      if (startConv) begin
        if (hiCnt != 8'hFF) hiCnt <= hiCnt + 8'd1;
      end else begin
        hiCnt <= '0;
      end
      if (startConv && !stPrev) sinceRise <= 16'd1;
      else if (sinceRise != 16'hFFFF) sinceRise <= sinceRise + 16'd1;
      if (!enable)                   seenRise <= 1'b0;
      else if (startConv && !stPrev) seenRise <= 1'b1;
      if (stPrev && !startConv) begin
        busyQ   <= 1'b1;
        busyCnt <= '0;
      end else if (eocPrev && !eoc) begin
        busyQ <= 1'b0;
      end else if (busyQ && busyCnt != 16'hFFFF) begin
        busyCnt <= busyCnt + 16'd1;
      end
    end
  end

  // R2: pulse width
  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stPrev && !startConv) |-> (hiCnt == 8'(PULSE_CYC)));

  // R3: spacing between start edges while running
  p_min_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startConv && !stPrev && seenRise) |-> (sinceRise >= 16'(MIN_PERIOD)));

  // R4: no start edge after eoc seen high
  p_no_start_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (startConv && !stPrev) |-> !eocPrev);

  // R5: single-cycle valid
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R6: config pins frozen during a conversion
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && (busyCnt < 16'(TIMEOUT_CYC - PULSE_CYC - 2))) |->
      ($stable(codingSel) && $stable(outEnN)));

  // R8: no sample while bus disabled
  p_valid_needs_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> !outEnN);

  // R9: sticky error
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

endmodule

bind adc_capture_ctrl adc_cap_checker #(
  .PULSE_CYC   (PULSE_USE),
  .MIN_PERIOD  (MIN_PERIOD),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .eoc         (eoc),
  .startConv   (startConv),
  .codingSel   (codingSel),
  .outEnN      (outEnN),
  .sampleValid (sampleValid),
  .errFlag     (errFlag)
);

// File: tb/adc_capture_ctrl_tb_top.sv
module adc_capture_ctrl_tb_top;

  localparam int NVEC     = 5;
  localparam int RISE_AT  = 10;
  localparam int FALL_AT  = 45;
  localparam int PULSE_EXP = 20;

  localparam logic [15:0] VEC_PERIOD [0:NVEC-1] = '{16'd60, 16'd80, 16'd20, 16'd0, 16'd90};
  localparam logic        VEC_COD    [0:NVEC-1] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int          VEC_SPACE  [0:NVEC-1] = '{60, 80, 60, 60, 90};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] periodCycles = 16'd60;
  logic        reqCoding = 1'b0;
  logic        reqRead = 1'b0;
  logic        eocM = 1'b0;
  logic        stuckEoc = 1'b0;
  logic        dropEoc = 1'b0;
  logic [13:0] mWord = '0;
  logic [13:0] mRaw = '0;
  logic        startConv, codingSel, outEnN, sampleValid, errFlag;
  logic [13:0] sampleData;
  wire         eoc = eocM | stuckEoc;
  wire  [13:0] adcBus = outEnN ? 14'bz : mWord;

  int numChecks = 0;
  int numFails  = 0;
  bit finished  = 0;

  always #2 clk = ~clk;

  adc_capture_ctrl dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .periodCycles(periodCycles),
    .reqCoding(reqCoding), .reqRead(reqRead), .eoc(eoc), .adcData(adcBus),
    .startConv(startConv), .codingSel(codingSel), .outEnN(outEnN),
    .sampleValid(sampleValid), .sampleData(sampleData), .errFlag(errFlag)
  );

  // behavioural converter
  logic startQ = 1'b0;
  logic mBusy = 1'b0;
  logic mDrop = 1'b0;
  logic mCod = 1'b0;
  int   mCnt = 0;
  int   convIdx = 0;
  int   violStart = 0;
  always @(posedge clk) begin
    startQ <= startConv;
    if (startConv && !startQ) begin
      if (eoc) violStart = violStart + 1;
      mBusy <= 1'b1;
      mCnt  <= 0;
      mDrop <= dropEoc;
      mCod  <= codingSel;
      mRaw  <= 14'((convIdx * 613) + 341);
      convIdx = convIdx + 1;
    end else if (mBusy) begin
      mCnt <= mCnt + 1;
      if (mCnt == RISE_AT) eocM <= !mDrop;
      if (mCnt == FALL_AT - 3) mWord <= mCod ? ~mRaw : mRaw;
      if (mCnt == FALL_AT) begin
        eocM  <= 1'b0;
        mBusy <= 1'b0;
      end
    end
  end

  // conversion-window config monitor
  logic cfgBusy = 1'b0;
  logic eocQ = 1'b0;
  logic codQ = 1'b0;
  logic oeQ = 1'b1;
  int   violCfg = 0;
  always @(posedge clk) begin
    eocQ <= eoc;
    codQ <= codingSel;
    oeQ  <= outEnN;
    if (cfgBusy && (codingSel != codQ || outEnN != oeQ)) violCfg = violCfg + 1;
    if (startQ && !startConv && !mDrop) cfgBusy <= 1'b1;
    else if (eocQ && !eoc) cfgBusy <= 1'b0;
  end

  // edge measurement at negedge
  int  cyc = 0;
  int  lastRise = 0;
  int  spacing = 0;
  int  pulseW = 0;
  int  riseCount = 0;
  int  fallCount = 0;
  int  validCount = 0;
  logic sPrevN = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (startConv && !sPrevN) begin
      riseCount = riseCount + 1;
      spacing   = cyc - lastRise;
      lastRise  = cyc;
    end
    if (!startConv && sPrevN) begin
      pulseW    = cyc - lastRise;
      fallCount = fallCount + 1;
    end
    if (sampleValid) validCount = validCount + 1;
    sPrevN = startConv;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    numChecks++;
    if (!ok) begin
      numFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitValid(input string req);
    int n = 0;
    @(negedge clk);
    while (!sampleValid && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(sampleValid == 1'b1, req, int'(sampleValid), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int r0;
    int v0;
    logic oldCod;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(startConv == 1'b0,   "R1 startConv",   int'(startConv), 0);
    check(sampleValid == 1'b0, "R1 sampleValid", int'(sampleValid), 0);
    check(errFlag == 1'b0,     "R1 errFlag",     int'(errFlag), 0);
    check(codingSel == 1'b0,   "R1 codingSel",   int'(codingSel), 0);
    check(outEnN == 1'b1,      "R1 outEnN",      int'(outEnN), 1);
    rstN = 1'b1;
    // R10: disabled, no start
    repeat (100) @(negedge clk);
    check(riseCount == 0, "R10 idle no start", riseCount, 0);
    check(outEnN == 1'b1, "R1 outEnN after reset", int'(outEnN), 1);

    reqRead = 1'b1;
    enable  = 1'b1;
    waitValid("R10 first sample");

    // table walk: R2 R3 R5 R7
    for (int i = 0; i < NVEC; i++) begin
      periodCycles = VEC_PERIOD[i];
      reqCoding    = VEC_COD[i];
      waitValid("R5 valid");
      waitValid("R5 valid");
      check(spacing == VEC_SPACE[i], "R3 spacing", spacing, VEC_SPACE[i]);
      check(pulseW == PULSE_EXP, "R2 pulse width", pulseW, PULSE_EXP);
      check(sampleData == (reqCoding ? ~mRaw : mRaw), "R7 coded word",
            int'(sampleData), int'(reqCoding ? ~mRaw : mRaw));
      check(codingSel == reqCoding, "R7 codingSel", int'(codingSel), int'(reqCoding));
      @(negedge clk);
      check(sampleValid == 1'b0, "R5 valid one cycle", int'(sampleValid), 0);
    end
    check(outEnN == 1'b0, "R8 bus enabled", int'(outEnN), 0);

    // R6: request change in mid-conversion
    periodCycles = 16'd60;
    r0 = fallCount;
    while (fallCount == r0) @(negedge clk);
    oldCod    = codingSel;
    reqCoding = ~reqCoding;
    repeat (5) @(negedge clk);
    check(codingSel == oldCod, "R6 held during conversion", int'(codingSel), int'(oldCod));
    waitValid("R6 valid");
    repeat (2) @(negedge clk);
    check(codingSel == reqCoding, "R6 applied after EOC", int'(codingSel), int'(reqCoding));

    // R8: bus disabled suppresses samples
    reqRead = 1'b0;
    repeat (70) @(negedge clk);
    v0 = validCount;
    repeat (300) @(negedge clk);
    check(outEnN == 1'b1, "R8 outEnN follows reqRead", int'(outEnN), 1);
    check(validCount == v0, "R8 no sample while disabled", validCount - v0, 0);
    reqRead = 1'b1;
    waitValid("R8 samples resume");
    check(errFlag == 1'b0, "R9 no error yet", int'(errFlag), 0);

    // R9: timeout
    dropEoc = 1'b1;
    r0 = riseCount;
    while (riseCount == r0) @(negedge clk);
    repeat (3) @(negedge clk);
    dropEoc = 1'b0;
    v0 = validCount;
    repeat (100) @(negedge clk);
    check(errFlag == 1'b1, "R9 timeout flag", int'(errFlag), 1);
    waitValid("R9 conversion continues");
    check(errFlag == 1'b1, "R9 flag sticky", int'(errFlag), 1);

    // R4: stuck EOC blocks starts
    stuckEoc = 1'b1;
    r0 = riseCount;
    repeat (300) @(negedge clk);
    check(riseCount == r0, "R4 no start while eoc high", riseCount - r0, 0);
    stuckEoc = 1'b0;
    waitValid("R4 resumes after eoc low");
    check(violStart == 0, "R4 model start-while-busy", violStart, 0);
    check(violCfg == 0, "R6 model config in conversion", violCfg, 0);

    // R10: disable stops conversions
    enable = 1'b0;
    repeat (80) @(negedge clk);
    r0 = riseCount;
    repeat (300) @(negedge clk);
    check(riseCount == r0, "R10 disabled no start", riseCount - r0, 0);
    finish_run();
  end

endmodule